// File: doc/BRIEF.md
# DMA Bus Opportunity Arbiter

This block lets one on-chip DMA channel borrow the shared memory bus from the CPU core. A receiver pushes bytes into a small FIFO inside the block. The arbiter watches a per-state indication from the CPU that says whether the CPU is about to present an address. It takes the bus only at such a point. The bus being idle is never enough.

Once it takes the bus, the block runs a fixed sequence of bus states. First comes one idle state, which hands the bus over. Then comes an address state, which presents the DMA pointer. Then comes a data state, which drives the oldest buffered byte. The data state is lengthened by a configured number of wait states and by an external not-ready request. After the data state the bus goes back to the CPU, the FIFO drops its head entry and the pointer advances.

If a byte arrives while the FIFO is full and no entry leaves in the same state, the byte is dropped. A sticky overrun flag is then raised and held until the host clears it.

Top module: `dma_bus_arbiter`

## Requirements
- R1: After reset, `bus_state` is CPU (2'b00), `fifo_level` is 0, `overrun` is 0 and `dma_addr` equals `BASE_ADDR`.
- R2: The bus leaves the CPU only at an edge where `cpu_addr_state` is 1, `cpu_extra_ale` is 0 and `fifo_level` is nonzero. While `cpu_addr_state` is 0, buffered data never starts a transfer.
- R3: A state with `cpu_addr_state` and `cpu_extra_ale` both at 1 is an extra latch pulse. It is not an opportunity, and `bus_state` stays CPU.
- R4: After a grant, `bus_state` shows IDLE (2'b01) for one state, then ADDR (2'b10) for one state, then DATA (2'b11) for 1+`wait_cfg` states while `ext_ready` is 1, and then CPU again.
- R5: A DATA state with `ext_ready` at 0 is always followed by another DATA state. DATA ends only after a state in which at least `wait_cfg` wait states have elapsed and `ext_ready` is 1.
- R6: During ADDR, `dma_addr` holds the pointer for the current transfer. It increases by one after each completed transfer and changes at no other time.
- R7: The FIFO holds up to three bytes, and `bus_wdata` during DATA is the oldest byte still held (first in, first out).
- R8: A push while the FIFO is full and no transfer is completing is dropped. The stored bytes and the level are left unchanged, and `overrun` is set and stays at 1.
- R9: A push in the same state in which a transfer completes on a full FIFO is accepted. The level stays at three and `overrun` is not set.
- R10: `ovr_clear` returns `overrun` to 0. If a drop happens in the same state as the clear, the flag is set.
- R11: Starting from an empty FIFO, bytes pushed during a run of states with no opportunity raise `overrun` exactly when more than three of them arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-state clock; one cycle is one bus state |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Receiver offers a byte this state |
| push_data | input | DW | Byte from the receiver |
| cpu_addr_state | input | 1 | CPU would present an address this state |
| cpu_extra_ale | input | 1 | This address state is an extra latch pulse of a split access |
| ext_ready | input | 1 | External device ready; 0 stretches the data state |
| wait_cfg | input | WW | Configured wait states per DMA access |
| ovr_clear | input | 1 | Host write that clears the overrun flag |
| bus_state | output | 2 | 00 CPU, 01 IDLE, 10 ADDR, 11 DATA |
| dma_own | output | 1 | DMA holds the bus (state is not CPU) |
| dma_addr | output | AW | DMA pointer, meaningful during ADDR |
| bus_wdata | output | DW | Head byte during DATA, zero otherwise |
| fifo_level | output | 2 | Bytes held, width $clog2(DEPTH+1) |
| overrun | output | 1 | Sticky overrun flag |

## Verification
A receiver push and a FIFO pop can fall in the same state. This happens when the last DATA state of a transfer coincides with a byte arriving. It is most telling when the FIFO is full. The bench fills the FIFO and then pushes a fourth byte during the DATA state that ends a transfer. It judges the result by a level of three, an overrun flag still at 0, and a drain order that runs second, third, fourth byte. A second case pushes into a full FIFO while the host clears the flag, and the set must win.

// File: rtl/dab_pkg.sv
package dab_pkg;

  typedef enum logic [1:0] {
    BS_CPU  = 2'b00,
    BS_IDLE = 2'b01,
    BS_ADDR = 2'b10,
    BS_DATA = 2'b11
  } bus_state_t;

  // Data phase may end once enough wait states have passed and the bus is ready.
  function automatic logic data_phase_done(input int unsigned served,
                                           input int unsigned cfg,
                                           input logic        rdy);
    return (served >= cfg) && rdy;
  endfunction

  // Occupancy after one state of traffic.
  function automatic int unsigned level_next(input int unsigned lvl,
                                             input logic        put,
                                             input logic        take);
    int unsigned n;
    n = lvl;
    if (put)  n = n + 1;
    if (take) n = n - 1;
    return n;
  endfunction

endpackage

// File: rtl/dab_fifo.sv
module dab_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [DW-1:0]                din,
  input  logic                         pop,
  output logic [DW-1:0]                head,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         empty,
  output logic                         push_ok,
  output logic                         drop
);
  import dab_pkg::*;

  localparam int LW = $clog2(DEPTH + 1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          full;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push && (!full || pop);
  assign drop    = push && full && !pop;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push_ok) begin
        mem[wr_ptr] <= din;
        wr_ptr      <= ptr_inc(wr_ptr);
      end
      if (pop) rd_ptr <= ptr_inc(rd_ptr);
      level <= LW'(level_next(32'(level), push_ok, pop));
    end
  end

endmodule

// File: rtl/dab_seq.sv
module dab_seq #(
  parameter int WW = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               have_data,
  input  logic               opp,
  input  logic               ext_ready,
  input  logic [WW-1:0]      wait_cfg,
  output dab_pkg::bus_state_t state,
  output logic               grant,
  output logic               pop
);
  import dab_pkg::*;

  logic [WW-1:0] wcnt;
  logic          done;

  assign grant = (state == BS_CPU) && have_data && opp;
  assign done  = data_phase_done(32'(wcnt), 32'(wait_cfg), ext_ready);
  assign pop   = (state == BS_DATA) && done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= BS_CPU;
      wcnt  <= '0;
    end else begin
      unique case (state)
        BS_CPU:  if (grant) state <= BS_IDLE;
        BS_IDLE: state <= BS_ADDR;
        BS_ADDR: state <= BS_DATA;
        BS_DATA: if (done) state <= BS_CPU;
        default: state <= BS_CPU;
      endcase
      if (state == BS_DATA && !done) begin
        if (wcnt != '1) wcnt <= wcnt + 1'b1;
      end else begin
        wcnt <= '0;
      end
    end
  end

endmodule

// File: rtl/dab_sticky.sv
module dab_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter #(
  parameter int          DW        = 8,
  parameter int          AW        = 16,
  parameter int          WW        = 3,
  parameter int          DEPTH     = 3,
  parameter logic [15:0] BASE_ADDR = 16'h0100
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        push_valid,
  input  logic [DW-1:0]               push_data,
  input  logic                        cpu_addr_state,
  input  logic                        cpu_extra_ale,
  input  logic                        ext_ready,
  input  logic [WW-1:0]               wait_cfg,
  input  logic                        ovr_clear,
  output logic [1:0]                  bus_state,
  output logic                        dma_own,
  output logic [AW-1:0]               dma_addr,
  output logic [DW-1:0]               bus_wdata,
  output logic [$clog2(DEPTH+1)-1:0]  fifo_level,
  output logic                        overrun
);
  import dab_pkg::*;

  bus_state_t    state;
  logic          opp, grant, seq_pop, fifo_empty, push_ok, push_drop;
  logic [DW-1:0] head;

  // Only a real address state qualifies; extra latch pulses act as waits.
  assign opp = cpu_addr_state && !cpu_extra_ale;

  dab_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push_valid), .din(push_data),
    .pop(seq_pop), .head(head), .level(fifo_level), .empty(fifo_empty),
    .push_ok(push_ok), .drop(push_drop)
  );

  dab_seq #(.WW(WW)) u_seq (
    .clk(clk), .rst_n(rst_n), .have_data(!fifo_empty), .opp(opp),
    .ext_ready(ext_ready), .wait_cfg(wait_cfg), .state(state),
    .grant(grant), .pop(seq_pop)
  );

  dab_sticky u_ovr (
    .clk(clk), .rst_n(rst_n), .set(push_drop), .clr(ovr_clear), .flag(overrun)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dma_addr <= AW'(BASE_ADDR);
    else if (seq_pop) dma_addr <= dma_addr + 1'b1;
  end

  assign bus_state = state;
  assign dma_own   = (state != BS_CPU);
  assign bus_wdata = (state == BS_DATA) ? head : '0;

endmodule

// File: rtl/dab_checker.sv
module dab_checker #(
  parameter int AW    = 16,
  parameter int DEPTH = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [1:0]                 bus_state,
  input logic                       cpu_addr_state,
  input logic                       cpu_extra_ale,
  input logic                       ext_ready,
  input logic                       push_valid,
  input logic                       ovr_clear,
  input logic                       overrun,
  input logic                       seq_pop,
  input logic [$clog2(DEPTH+1)-1:0] fifo_level,
  input logic [AW-1:0]              dma_addr
);
  localparam int LW = $clog2(DEPTH + 1);

  // R2 / R3: no leaving the CPU without a qualified opportunity
  a_r2_grant_needs_opp: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_state == 2'b00 && !(cpu_addr_state && !cpu_extra_ale)) |=> bus_state == 2'b00);

  a_r2_no_grant_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_state == 2'b00 && fifo_level == '0) |=> bus_state == 2'b00);

  // R4: state ordering
  a_r4_cpu_exit_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    bus_state == 2'b00 |=> (bus_state == 2'b00 || bus_state == 2'b01));
  a_r4_idle_then_addr: assert property (@(posedge clk) disable iff (!rst_n)
    bus_state == 2'b01 |=> bus_state == 2'b10);
  a_r4_addr_then_data: assert property (@(posedge clk) disable iff (!rst_n)
    bus_state == 2'b10 |=> bus_state == 2'b11);

  // R5: not ready keeps the data state
  a_r5_wait_holds_data: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_state == 2'b11 && !ext_ready) |=> bus_state == 2'b11);

  // R6: pointer moves only with a completed transfer
  a_r6_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_pop |=> $stable(dma_addr));

  // R7: bounded occupancy
  a_r7_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LW'(DEPTH));

  // R8: drop keeps the level and raises a sticky flag
  a_r8_drop_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && fifo_level == LW'(DEPTH) && !seq_pop) |=> (fifo_level == LW'(DEPTH) && overrun));
  a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clear) |=> overrun);

  // R10: clear without a drop lowers the flag
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_clear && !(push_valid && fifo_level == LW'(DEPTH) && !seq_pop)) |=> !overrun);

endmodule

bind dma_bus_arbiter dab_checker #(.AW(AW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_state(bus_state), .cpu_addr_state(cpu_addr_state),
  .cpu_extra_ale(cpu_extra_ale), .ext_ready(ext_ready), .push_valid(push_valid),
  .ovr_clear(ovr_clear), .overrun(overrun), .seq_pop(seq_pop),
  .fifo_level(fifo_level), .dma_addr(dma_addr)
);

// File: tb/sim_dma_bus_arbiter.sv
`timescale 1ns/1ps
module sim_dma_bus_arbiter;
  localparam int DW = 8, AW = 16, WW = 3, DEPTH = 3;
  localparam logic [15:0] BASE = 16'h0100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic push_valid = 0, cpu_addr_state = 0, cpu_extra_ale = 0, ext_ready = 1, ovr_clear = 0;
  logic [DW-1:0] push_data = '0;
  logic [WW-1:0] wait_cfg = '0;
  logic [1:0] bus_state;
  logic dma_own, overrun;
  logic [AW-1:0] dma_addr;
  logic [DW-1:0] bus_wdata;
  logic [1:0] fifo_level;

  int n_chk = 0, n_bad = 0;
  logic [AW-1:0] exp_addr;
  bit finished = 0;

  always #4 clk = ~clk;

  dma_bus_arbiter #(.DW(DW), .AW(AW), .WW(WW), .DEPTH(DEPTH), .BASE_ADDR(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
    .cpu_addr_state(cpu_addr_state), .cpu_extra_ale(cpu_extra_ale), .ext_ready(ext_ready),
    .wait_cfg(wait_cfg), .ovr_clear(ovr_clear), .bus_state(bus_state), .dma_own(dma_own),
    .dma_addr(dma_addr), .bus_wdata(bus_wdata), .fifo_level(fifo_level), .overrun(overrun)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push1(input logic [7:0] b);
    push_valid = 1; push_data = b; tick(); push_valid = 0;
  endtask

  // One full transfer with no wait states; checks the delivered byte (R7).
  task automatic drain_one(input logic [7:0] b);
    wait_cfg = 0; ext_ready = 1;
    cpu_addr_state = 1; tick(); cpu_addr_state = 0;
    check("R4 idle", 32'(bus_state), 32'd1);
    tick(); check("R6 addr", 32'(dma_addr), 32'(exp_addr));
    tick(); check("R7 order", 32'(bus_wdata), 32'(b));
    tick(); check("R4 back to cpu", 32'(bus_state), 32'd0);
    exp_addr++;
  endtask

  task automatic t_reset();   // R1
    check("R1 state", 32'(bus_state), 0);
    check("R1 level", 32'(fifo_level), 0);
    check("R1 overrun", 32'(overrun), 0);
    check("R1 addr", 32'(dma_addr), 32'(BASE));
  endtask

  task automatic t_idle_bus();   // R2
    push1(8'h11);
    for (int i = 0; i < 10; i++) begin
      tick(); check("R2 idle bus no grant", 32'(bus_state), 0);
    end
    check("R2 byte kept", 32'(fifo_level), 1);
  endtask

  task automatic t_extra_ale();   // R3
    cpu_addr_state = 1; cpu_extra_ale = 1;
    for (int i = 0; i < 5; i++) begin
      tick(); check("R3 extra latch no grant", 32'(dma_own), 0);
    end
    cpu_addr_state = 0; cpu_extra_ale = 0;
  endtask

  task automatic t_sequence();   // R4 R6 with two wait states
    wait_cfg = 2; ext_ready = 1;
    cpu_addr_state = 1; tick(); cpu_addr_state = 0;
    check("R4 idle", 32'(bus_state), 1);
    tick(); check("R4 addr", 32'(bus_state), 2);
    check("R6 addr value", 32'(dma_addr), 32'(exp_addr));
    for (int i = 0; i < 3; i++) begin
      tick(); check("R4 data", 32'(bus_state), 3);
      check("R7 data byte", 32'(bus_wdata), 32'h11);
    end
    tick(); check("R4 return", 32'(bus_state), 0);
    exp_addr++;
    check("R6 addr step", 32'(dma_addr), 32'(exp_addr));
    check("R4 level", 32'(fifo_level), 0);
  endtask

  task automatic t_not_ready();   // R5
    push1(8'h22);
    wait_cfg = 0; ext_ready = 1;
    cpu_addr_state = 1; tick(); cpu_addr_state = 0;
    tick(); ext_ready = 0;
    for (int i = 0; i < 3; i++) begin
      tick(); check("R5 stretched data", 32'(bus_state), 3);
    end
    ext_ready = 1;
    tick(); check("R5 release", 32'(bus_state), 0);
    exp_addr++;
    check("R6 addr after stretch", 32'(dma_addr), 32'(exp_addr));
  endtask

  task automatic t_overrun();   // R7 R8 R10
    push1(8'hA1); check("R7 level1", 32'(fifo_level), 1);
    push1(8'hA2); check("R7 level2", 32'(fifo_level), 2);
    push1(8'hA3); check("R7 level3", 32'(fifo_level), 3);
    check("R8 no overrun yet", 32'(overrun), 0);
    push1(8'hA4);
    check("R8 level held", 32'(fifo_level), 3);
    check("R8 overrun set", 32'(overrun), 1);
    drain_one(8'hA1); drain_one(8'hA2); drain_one(8'hA3);
    check("R8 dropped byte absent", 32'(fifo_level), 0);
    check("R8 sticky", 32'(overrun), 1);
    ovr_clear = 1; tick(); ovr_clear = 0;
    check("R10 cleared", 32'(overrun), 0);
  endtask

  task automatic t_push_pop_full();   // R9
    push1(8'hB1); push1(8'hB2); push1(8'hB3);
    wait_cfg = 0; ext_ready = 1;
    cpu_addr_state = 1; tick(); cpu_addr_state = 0;
    tick(); tick();
    check("R9 in data", 32'(bus_state), 3);
    push_valid = 1; push_data = 8'hB4; tick(); push_valid = 0;
    exp_addr++;
    check("R9 level", 32'(fifo_level), 3);
    check("R9 no overrun", 32'(overrun), 0);
    drain_one(8'hB2); drain_one(8'hB3); drain_one(8'hB4);
  endtask

  task automatic t_clear_vs_set();   // R10
    push1(8'hC1); push1(8'hC2); push1(8'hC3);
    push_valid = 1; push_data = 8'hC4; ovr_clear = 1; tick();
    push_valid = 0; ovr_clear = 0;
    check("R10 set wins", 32'(overrun), 1);
    ovr_clear = 1; tick(); ovr_clear = 0;
    check("R10 clear", 32'(overrun), 0);
    drain_one(8'hC1); drain_one(8'hC2); drain_one(8'hC3);
  endtask

  // R11: bytes every 4 states during a gap of g states without an opportunity.
  task automatic t_gap(input int g);
    int n = 0;
    for (int i = 0; i < g; i++) begin
      push_valid = (i % 4 == 0); push_data = 8'(8'hD0 + n);
      if (i % 4 == 0) n++;
      tick();
    end
    push_valid = 0;
    check($sformatf("R11 gap %0d overrun", g), 32'(overrun), (n > DEPTH) ? 1 : 0);
    check($sformatf("R11 gap %0d level", g), 32'(fifo_level), 32'((n > DEPTH) ? DEPTH : n));
    ovr_clear = 1; tick(); ovr_clear = 0;
    for (int k = 0; k < ((n > DEPTH) ? DEPTH : n); k++) drain_one(8'(8'hD0 + k));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    exp_addr = BASE;
    tick(); tick();
    rst_n = 1;
    tick();
    t_reset();
    t_idle_bus();
    t_extra_ale();
    t_sequence();
    t_not_ready();
    t_overrun();
    t_push_pop_full();
    t_clear_vs_set();
    t_gap(8);
    t_gap(12);
    t_gap(13);
    t_gap(20);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule